// File: doc/BRIEF.md
# Single-Precision Predicate Comparator

This block compares two 32-bit binary floating-point operands and evaluates one of eight comparison predicates, selected by a 3-bit code. The answer comes back as a full-width mask, either every bit set (true) or every bit clear (false). Such a mask can be ANDed straight into select logic. An invalid-operation flag comes back with it. NaN operands make the ordering partial, so the negated predicates are separate conditions and not aliases of the ordered ones.

Ordering of non-NaN operands is decided from the sign bit and from the magnitude (exponent and fraction) compared as an unsigned number. Two zeros of either sign are equal, and infinities fall naturally at the two ends of the range. The core is combinational. A parameter adds one output register stage, which is the default.

Top module: `fcmp_unit`

## Requirements
- R1: The predicate code selects the condition: 0 equal, 1 less-than, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less-than, 6 not-less-or-equal, 7 ordered.
- R2: The mask output is all ones when the selected predicate holds and all zeros otherwise.
- R3: Equal, less-than and less-or-equal are false whenever either operand is a NaN (exponent all ones, fraction nonzero), including a NaN compared with itself.
- R4: Not-equal, not-less-than and not-less-or-equal are true whenever either operand is a NaN.
- R5: Unordered is true exactly when at least one operand is a NaN. Ordered is its complement.
- R6: Positive zero and negative zero compare equal, and neither is less than the other.
- R7: For non-NaN operands a negative value is below a positive one. Among positive values a larger magnitude is greater, and among negative values a larger magnitude is smaller.
- R8: Negative infinity is below every other non-NaN value, positive infinity is above every other, and each infinity equals itself.
- R9: Less-than, less-or-equal, not-less-than and not-less-or-equal raise the invalid flag when either operand is any NaN.
- R10: Equal, not-equal, unordered and ordered raise the invalid flag only when an operand is a signaling NaN (exponent all ones, fraction nonzero, fraction MSB zero). A quiet NaN (fraction MSB one) does not raise it.
- R11: With the output register enabled, mask and invalid are zero during reset, and a result appears one clock after its operands are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_a | input | 32 | Left operand, single-precision bit pattern |
| op_b | input | 32 | Right operand, single-precision bit pattern |
| pred | input | 3 | Predicate code per R1 |
| mask | output | 32 | All-ones if the predicate holds, else all-zeros |
| invalid | output | 1 | Invalid-operation indication for this comparison |

## Verification
The only state in the block is the output register, so a wrong internal value becomes visible on the mask or invalid pins in the cycle after the operands that produced it, and it is overwritten by the next result. A fault in classification shows up as a wrong answer on the NaN, zero and infinity patterns. Mixing up the ordering shows up on same-sign negative pairs, and a swapped predicate decode shows up as an inverted mask on a pair that has a known answer. Each scenario therefore drives operand pairs whose answers differ between the predicate and its neighbour, and samples one clock later.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int unsigned FP_EXP_W  = 8;
    localparam int unsigned FP_FRAC_W = 23;
    localparam int unsigned FP_W      = FP_EXP_W + FP_FRAC_W + 1;
    localparam int unsigned PRED_W    = 3;

    // Code values are fixed: callers encode the predicate as an immediate.
    typedef enum logic [PRED_W-1:0] {
        PRED_EQ    = 3'd0,
        PRED_LT    = 3'd1,
        PRED_LE    = 3'd2,
        PRED_UNORD = 3'd3,
        PRED_NEQ   = 3'd4,
        PRED_NLT   = 3'd5,
        PRED_NLE   = 3'd6,
        PRED_ORD   = 3'd7
    } pred_e;

    // Ordering predicates flag any NaN, the others flag signaling NaNs only.
    function automatic logic pred_traps_qnan(input pred_e p);
        return (p == PRED_LT) || (p == PRED_LE) ||
               (p == PRED_NLT) || (p == PRED_NLE);
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
    parameter int unsigned EXP_W  = fcmp_pkg::FP_EXP_W,
    parameter int unsigned FRAC_W = fcmp_pkg::FP_FRAC_W,
    localparam int unsigned W     = EXP_W + FRAC_W + 1,
    localparam int unsigned MAG_W = EXP_W + FRAC_W
) (
    input  logic [W-1:0]     op,
    output logic             sign,
    output logic [MAG_W-1:0] mag,
    output logic             is_nan,
    output logic             is_snan,
    output logic             is_zero
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;

    always_comb begin
        sign    = op[W-1];
        mag     = op[MAG_W-1:0];
        exp_f   = op[MAG_W-1:FRAC_W];
        frac_f  = op[FRAC_W-1:0];
        exp_max = &exp_f;
        is_nan  = exp_max && (|frac_f);
        // quiet bit is the top fraction bit
        is_snan = is_nan && !frac_f[FRAC_W-1];
        is_zero = (mag == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
    parameter int unsigned MAG_W = fcmp_pkg::FP_EXP_W + fcmp_pkg::FP_FRAC_W
) (
    input  logic             sign_a,
    input  logic [MAG_W-1:0] mag_a,
    input  logic             zero_a,
    input  logic             sign_b,
    input  logic [MAG_W-1:0] mag_b,
    input  logic             zero_b,
    output logic             a_eq_b,
    output logic             a_lt_b
);
    // Valid only for non-NaN operands; NaN handling lives in the selector.
    logic both_zero;
    logic mag_lt;
    logic mag_gt;

    always_comb begin
        both_zero = zero_a && zero_b;
        mag_lt    = mag_a < mag_b;
        mag_gt    = mag_a > mag_b;
        a_eq_b    = both_zero || ((sign_a == sign_b) && (mag_a == mag_b));
        unique case ({sign_a, sign_b})
            2'b00:   a_lt_b = mag_lt;
            2'b11:   a_lt_b = mag_gt;
            2'b10:   a_lt_b = !both_zero;
            default: a_lt_b = 1'b0;
        endcase
    end
endmodule

// File: rtl/fcmp_pred_sel.sv
module fcmp_pred_sel
    import fcmp_pkg::*;
(
    input  pred_e pred,
    input  logic  unord,
    input  logic  any_snan,
    input  logic  a_eq_b,
    input  logic  a_lt_b,
    output logic  hit,
    output logic  raise_inv
);
    logic ord_eq;
    logic ord_lt;
    logic ord_le;

    always_comb begin
        ord_eq = !unord && a_eq_b;
        ord_lt = !unord && a_lt_b;
        ord_le = ord_eq || ord_lt;
        unique case (pred)
            PRED_EQ:    hit = ord_eq;
            PRED_LT:    hit = ord_lt;
            PRED_LE:    hit = ord_le;
            PRED_UNORD: hit = unord;
            PRED_NEQ:   hit = !ord_eq;
            PRED_NLT:   hit = !ord_lt;
            PRED_NLE:   hit = !ord_le;
            default:    hit = !unord;
        endcase
        raise_inv = pred_traps_qnan(pred) ? unord : any_snan;
    end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int unsigned EXP_W   = FP_EXP_W,
    parameter int unsigned FRAC_W  = FP_FRAC_W,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned W      = EXP_W + FRAC_W + 1,
    localparam int unsigned MAG_W  = EXP_W + FRAC_W,
    localparam int unsigned N_OPS  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        op_a,
    input  logic [W-1:0]        op_b,
    input  logic [PRED_W-1:0]   pred,
    output logic [W-1:0]        mask,
    output logic                invalid
);
    typedef struct packed {
        logic [W-1:0] mask;
        logic         invalid;
    } result_t;

    logic [W-1:0]     ops     [N_OPS];
    logic             sgn     [N_OPS];
    logic [MAG_W-1:0] mag     [N_OPS];
    logic             nan_f   [N_OPS];
    logic             snan_f  [N_OPS];
    logic             zero_f  [N_OPS];

    logic    a_eq_b;
    logic    a_lt_b;
    logic    hit;
    logic    raise_inv;
    result_t res_d;
    result_t res_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .op      (ops[i]),
            .sign    (sgn[i]),
            .mag     (mag[i]),
            .is_nan  (nan_f[i]),
            .is_snan (snan_f[i]),
            .is_zero (zero_f[i])
        );
    end

    fcmp_order #(.MAG_W(MAG_W)) u_ord (
        .sign_a (sgn[0]),
        .mag_a  (mag[0]),
        .zero_a (zero_f[0]),
        .sign_b (sgn[1]),
        .mag_b  (mag[1]),
        .zero_b (zero_f[1]),
        .a_eq_b (a_eq_b),
        .a_lt_b (a_lt_b)
    );

    fcmp_pred_sel u_sel (
        .pred      (pred_e'(pred)),
        .unord     (nan_f[0] || nan_f[1]),
        .any_snan  (snan_f[0] || snan_f[1]),
        .a_eq_b    (a_eq_b),
        .a_lt_b    (a_lt_b),
        .hit       (hit),
        .raise_inv (raise_inv)
    );

    always_comb begin
        res_d         = '0;
        res_d.mask    = {W{hit}};
        res_d.invalid = raise_inv;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign mask    = res_q.mask;
    assign invalid = res_q.invalid;
endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk #(
    parameter int unsigned W       = 32,
    parameter int unsigned FRAC_W  = 23,
    parameter bit          REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [2:0]   pred,
    input logic [W-1:0] mask,
    input logic         invalid
);
    logic [W-1:0] a_s;
    logic [W-1:0] b_s;
    logic [2:0]   p_s;
    logic         seen;

    if (REG_OUT) begin : g_lat
        always_ff @(posedge clk) begin
            a_s  <= op_a;
            b_s  <= op_b;
            p_s  <= pred;
            seen <= rst_n;
        end
    end else begin : g_now
        assign a_s  = op_a;
        assign b_s  = op_b;
        assign p_s  = pred;
        assign seen = 1'b1;
    end

    function automatic logic nan_of(input logic [W-1:0] v);
        return (&v[W-2:FRAC_W]) && (|v[FRAC_W-1:0]);
    endfunction

    logic any_nan;
    logic both_zero;
    assign any_nan   = nan_of(a_s) || nan_of(b_s);
    assign both_zero = (a_s[W-2:0] == '0) && (b_s[W-2:0] == '0);

    // R2
    mask_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (mask == '0 || mask == '1));

    // R3
    nan_eq_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && any_nan && p_s <= 3'd2) |-> (mask == '0));

    // R4
    nan_negated_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && any_nan && p_s >= 3'd4 && p_s <= 3'd6) |-> (mask == '1));

    // R5
    unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && p_s == 3'd3) |-> ((mask == '1) == any_nan));

    // R6
    zero_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && both_zero && p_s == 3'd0) |-> (mask == '1));

    // R9
    trap_qnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && any_nan && (p_s == 3'd1 || p_s == 3'd2 || p_s == 3'd5 || p_s == 3'd6))
        |-> invalid);

    // R10
    quiet_no_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !any_nan) |-> !invalid);
endmodule

bind fcmp_unit fcmp_unit_chk #(.W(W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a    (op_a),
    .op_b    (op_b),
    .pred    (pred),
    .mask    (mask),
    .invalid (invalid)
);

// File: tb/sim_fcmp_unit.sv
`timescale 1ns/1ps
module sim_fcmp_unit;
    localparam logic [31:0] PZ   = 32'h0000_0000;
    localparam logic [31:0] NZ   = 32'h8000_0000;
    localparam logic [31:0] P1   = 32'h3F80_0000;
    localparam logic [31:0] P2   = 32'h4000_0000;
    localparam logic [31:0] N1   = 32'hBF80_0000;
    localparam logic [31:0] N2   = 32'hC000_0000;
    localparam logic [31:0] PINF = 32'h7F80_0000;
    localparam logic [31:0] NINF = 32'hFF80_0000;
    localparam logic [31:0] QNAN = 32'h7FC0_0000;
    localparam logic [31:0] SNAN = 32'h7F80_0001;
    localparam logic [31:0] DMIN = 32'h0000_0001;
    localparam logic [31:0] PMAX = 32'h7F7F_FFFF;
    localparam logic [31:0] NMAX = 32'hFF7F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [2:0]  pred = '0;
    logic [31:0] mask;
    logic        invalid;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    fcmp_unit u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_a    (op_a),
        .op_b    (op_b),
        .pred    (pred),
        .mask    (mask),
        .invalid (invalid)
    );

    task automatic cmp(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] p, input bit exp_t, input bit exp_inv);
        logic [31:0] exp_m;
        exp_m = exp_t ? 32'hFFFF_FFFF : 32'h0;
        @(negedge clk);
        op_a = a; op_b = b; pred = p;
        @(posedge clk);
        #2;
        n_run++;
        if (mask !== exp_m || invalid !== exp_inv) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h p=%0d: mask=%h inv=%b expected mask=%h inv=%b",
                     req, a, b, p, mask, invalid, exp_m, exp_inv);
        end
    endtask

    task automatic t_reset();
        // R11: reset state
        n_run++;
        if (mask !== 32'h0 || invalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 reset: mask=%h inv=%b expected 0/0", mask, invalid);
        end
    endtask

    task automatic t_latency();
        // R11: one-cycle latency, operands change then result follows
        @(negedge clk);
        op_a = P1; op_b = P2; pred = 3'd1;
        @(posedge clk); #2;
        @(negedge clk);
        op_a = P2; op_b = P1;
        #1;
        n_run++;
        if (mask !== 32'hFFFF_FFFF) begin
            n_fail++;
            $display("FAIL R11 hold: mask=%h expected ffffffff", mask);
        end
        @(posedge clk); #2;
        n_run++;
        if (mask !== 32'h0) begin
            n_fail++;
            $display("FAIL R11 update: mask=%h expected 00000000", mask);
        end
    endtask

    task automatic t_decode();
        // R1 R2: 1.0 vs 2.0 through all eight codes
        cmp("R1", P1, P2, 3'd0, 0, 0);
        cmp("R1", P1, P2, 3'd1, 1, 0);
        cmp("R1", P1, P2, 3'd2, 1, 0);
        cmp("R1", P1, P2, 3'd3, 0, 0);
        cmp("R1", P1, P2, 3'd4, 1, 0);
        cmp("R2", P1, P2, 3'd5, 0, 0);
        cmp("R2", P1, P2, 3'd6, 0, 0);
        cmp("R2", P1, P2, 3'd7, 1, 0);
        cmp("R1", P2, P2, 3'd2, 1, 0);
        cmp("R1", P2, P2, 3'd1, 0, 0);
    endtask

    task automatic t_nan_quiet();
        // R3 R4 R5 R9 R10 with a quiet NaN
        cmp("R3", QNAN, QNAN, 3'd0, 0, 0);
        cmp("R3", QNAN, P1,   3'd1, 0, 1);
        cmp("R3", P1,   QNAN, 3'd2, 0, 1);
        cmp("R4", P1,   QNAN, 3'd4, 1, 0);
        cmp("R4", QNAN, P1,   3'd5, 1, 1);
        cmp("R4", QNAN, NINF, 3'd6, 1, 1);
        cmp("R5", P1,   QNAN, 3'd3, 1, 0);
        cmp("R5", QNAN, P1,   3'd7, 0, 0);
        cmp("R5", P1,   N1,   3'd7, 1, 0);
        cmp("R9", NINF, QNAN, 3'd1, 0, 1);
        cmp("R10", QNAN, P1,  3'd0, 0, 0);
    endtask

    task automatic t_nan_signal();
        // R10 R9 with a signaling NaN
        cmp("R10", SNAN, P1,   3'd0, 0, 1);
        cmp("R10", P1,   SNAN, 3'd4, 1, 1);
        cmp("R10", SNAN, SNAN, 3'd3, 1, 1);
        cmp("R10", P1,   SNAN, 3'd7, 0, 1);
        cmp("R9",  SNAN, P1,   3'd6, 1, 1);
    endtask

    task automatic t_zero();
        // R6
        cmp("R6", PZ, NZ, 3'd0, 1, 0);
        cmp("R6", NZ, PZ, 3'd1, 0, 0);
        cmp("R6", PZ, NZ, 3'd1, 0, 0);
        cmp("R6", NZ, PZ, 3'd2, 1, 0);
        cmp("R6", NZ, PZ, 3'd4, 0, 0);
    endtask

    task automatic t_order();
        // R7: sign and magnitude, reversed for negatives
        cmp("R7", N1, P1, 3'd1, 1, 0);
        cmp("R7", P1, N1, 3'd1, 0, 0);
        cmp("R7", N2, N1, 3'd1, 1, 0);
        cmp("R7", N1, N2, 3'd1, 0, 0);
        cmp("R7", N1, N2, 3'd6, 1, 0);
        cmp("R7", PZ, DMIN, 3'd1, 1, 0);
        cmp("R7", N1, PZ, 3'd1, 1, 0);
        cmp("R7", N1, N1, 3'd0, 1, 0);
        cmp("R7", N1, P1, 3'd0, 0, 0);
    endtask

    task automatic t_inf();
        // R8
        cmp("R8", NINF, NMAX, 3'd1, 1, 0);
        cmp("R8", PMAX, PINF, 3'd1, 1, 0);
        cmp("R8", PINF, PINF, 3'd0, 1, 0);
        cmp("R8", NINF, NINF, 3'd2, 1, 0);
        cmp("R8", PINF, NINF, 3'd5, 1, 0);
        cmp("R8", NINF, PINF, 3'd1, 1, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_decode();
        t_latency();
        t_nan_quiet();
        t_nan_signal();
        t_zero();
        t_order();
        t_inf();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule